// File: doc/BRIEF.md
# Event Log Ring Writer

This block appends fixed-size event records to a circular log whose storage sits outside the block, behind a simple write port. A producer offers events on a valid/ready input. When logging is running and the ring has room, each event becomes one record write at the tail slot, and the tail then advances with wrap-around. Software drains the log by reading records and moving the head pointer forward through a small register interface. The block uses the head pointer only to work out how much free space remains.

When an event arrives while the ring is full, the event is dropped and a sticky overflow flag is set. Logging then freezes, and it stays frozen even after software frees space. To resume, software clears the flag and then takes the log enable bit from 0 to 1. Writing enable as 1 again while it already reads 1 does not resume logging. An interrupt line reports the overflow whenever the interrupt enable bit is set.

Top module: `evlog_writer`

## Requirements
- R1: After a synchronous reset, the control register reads 0, the head and tail pointers read 0, irq is 0 and no record write takes place.
- R2: Register addresses are: 0 for control, 1 for head (read/write), 2 for tail (read-only; writes are ignored). In control, bit 0 is log enable, bit 1 is interrupt enable and bit 2 is the overflow flag. Read data appears one cycle after the read address is presented.
- R3: Each event accepted while logging runs produces exactly one record write of the event data at the current tail. The write appears on the memory port one cycle after the handshake, and the tail has advanced by one in that same cycle.
- R4: With N = 2^IDX_W entries, the ring is full when tail+1 (mod N) equals head, so at most N-1 records are outstanding.
- R5: An event that finds the ring full is not written, the tail does not move, and the overflow flag becomes 1.
- R6: The overflow flag is cleared by writing 1 to control bit 2. Writing 0 to that bit leaves the flag unchanged.
- R7: irq equals overflow AND interrupt enable, and it changes in the same cycle as the register values it follows.
- R8: After an overflow, no record is written, even if software has since freed space by moving head.
- R9: ev_ready is 1 in every cycle after reset. Events presented while logging is disabled or halted are discarded: they cause no write and do not set overflow.
- R10: After an overflow, logging resumes only on a write that takes enable from 0 to 1 while the overflow flag already reads 0. Rewriting enable as 1 when it is already 1 does not resume logging.
- R11: A single control write that clears the overflow flag and also raises enable from 0 to 1 does not resume logging.
- R12: The tail wraps from N-1 to 0, and records keep going to the correct slots across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | Producer offers an event |
| ev_ready | output | 1 | Block takes the offered event |
| ev_data | input | REC_W | Event record contents |
| reg_wr_en | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | REG_W | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | REG_W | Registered read data |
| mem_we | output | 1 | Record write strobe to log storage |
| mem_addr | output | IDX_W | Slot index of the record write |
| mem_wdata | output | REC_W | Record written to the slot |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with IDX_W = 2 and REC_W = 16. This gives a four-slot ring with three usable slots, so a few events are enough to fill it, overflow it, wrap the tail past slot 3 and fill it again. With the ring this small, the halted state can be driven through every resume path: rewriting enable as 1, a single combined clear-and-enable write, and the proper clear followed by a 0-then-1 toggle of enable. Each path is judged by the record writes that follow it.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_HEAD = 2'd1,
    RA_TAIL = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  localparam int EN_BIT  = 0;
  localparam int IE_BIT  = 1;
  localparam int OVF_BIT = 2;
  localparam int CTRL_BITS = 3;

endpackage

// File: rtl/evlog_ctrl.sv
module evlog_ctrl
  import evlog_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       waddr,
  input  logic [REG_W-1:0] wdata,
  input  logic [1:0]       raddr,
  input  logic [IDX_W-1:0] tail,
  input  logic             ovf_hit,
  output logic [REG_W-1:0] rdata,
  output logic [IDX_W-1:0] head,
  output logic             log_active,
  output logic             ovf,
  output logic             ie,
  output logic             halt,
  output logic             irq
);

  logic             en_q, ie_q, ovf_q, halt_q, irq_q;
  logic             en_d, ie_d, ovf_d, halt_d;
  logic [IDX_W-1:0] head_q, head_d;
  logic [REG_W-1:0] rdata_q, rdata_d;
  logic             ctrl_wr, head_wr, en_rise;

  assign ctrl_wr = wr_en && (reg_addr_e'(waddr) == RA_CTRL);
  assign head_wr = wr_en && (reg_addr_e'(waddr) == RA_HEAD);
  assign en_rise = ctrl_wr && wdata[EN_BIT] && !en_q;

  always_comb begin
    en_d   = en_q;
    ie_d   = ie_q;
    ovf_d  = ovf_q;
    halt_d = halt_q;
    head_d = head_q;
    if (ctrl_wr) begin
      en_d = wdata[EN_BIT];
      ie_d = wdata[IE_BIT];
      if (wdata[OVF_BIT]) ovf_d = 1'b0;
      // resume only if the flag was already clear before this write
      if (en_rise && !ovf_q) halt_d = 1'b0;
    end
    if (head_wr) head_d = wdata[IDX_W-1:0];
    if (ovf_hit) begin
      ovf_d  = 1'b1;
      halt_d = 1'b1;
    end
  end

  always_comb begin
    rdata_d = '0;
    case (reg_addr_e'(raddr))
      RA_CTRL: begin
        rdata_d[EN_BIT]  = en_q;
        rdata_d[IE_BIT]  = ie_q;
        rdata_d[OVF_BIT] = ovf_q;
      end
      RA_HEAD: rdata_d[IDX_W-1:0] = head_q;
      RA_TAIL: rdata_d[IDX_W-1:0] = tail;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      ovf_q   <= 1'b0;
      halt_q  <= 1'b0;
      head_q  <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      ie_q    <= ie_d;
      ovf_q   <= ovf_d;
      halt_q  <= halt_d;
      head_q  <= head_d;
      irq_q   <= ovf_d & ie_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata      = rdata_q;
  assign head       = head_q;
  assign log_active = en_q && !halt_q && !ovf_q;
  assign ovf        = ovf_q;
  assign ie         = ie_q;
  assign halt       = halt_q;
  assign irq        = irq_q;

endmodule

// File: rtl/evlog_ring.sv
module evlog_ring #(
  parameter int REC_W = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             ev_valid,
  input  logic [REC_W-1:0] ev_data,
  input  logic [IDX_W-1:0] head,
  output logic             ev_ready,
  output logic [IDX_W-1:0] tail,
  output logic             ovf_hit,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_addr,
  output logic [REC_W-1:0] mem_wdata
);

  logic             ready_q;
  logic [IDX_W-1:0] tail_q, tail_inc;
  logic             full, fire, accept;
  logic             we_q;
  logic [IDX_W-1:0] addr_q;
  logic [REC_W-1:0] data_q;

  assign tail_inc = tail_q + 1'b1;
  assign full     = (tail_inc == head);
  assign fire     = ev_valid && ready_q;
  assign accept   = fire && active && !full;
  assign ovf_hit  = fire && active && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      tail_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      ready_q <= 1'b1;
      we_q    <= accept;
      if (accept) begin
        addr_q <= tail_q;
        data_q <= ev_data;
        tail_q <= tail_inc;
      end
    end
  end

  assign ev_ready  = ready_q;
  assign tail      = tail_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

endmodule

// File: rtl/evlog_writer.sv
module evlog_writer #(
  parameter  int REC_W = 32,
  parameter  int IDX_W = 3,
  localparam int REG_W = (IDX_W > 3) ? IDX_W : 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [REC_W-1:0] ev_data,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_waddr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [1:0]       reg_raddr,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_addr,
  output logic [REC_W-1:0] mem_wdata,
  output logic             irq
);

  logic [IDX_W-1:0] head_w, tail_w;
  logic             active_w, ovf_hit_w, ovf_w, ie_w, halt_w;

  evlog_ctrl #(.IDX_W(IDX_W), .REG_W(REG_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr_en),
    .waddr      (reg_waddr),
    .wdata      (reg_wdata),
    .raddr      (reg_raddr),
    .tail       (tail_w),
    .ovf_hit    (ovf_hit_w),
    .rdata      (reg_rdata),
    .head       (head_w),
    .log_active (active_w),
    .ovf        (ovf_w),
    .ie         (ie_w),
    .halt       (halt_w),
    .irq        (irq)
  );

  evlog_ring #(.REC_W(REC_W), .IDX_W(IDX_W)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .active    (active_w),
    .ev_valid  (ev_valid),
    .ev_data   (ev_data),
    .head      (head_w),
    .ev_ready  (ev_ready),
    .tail      (tail_w),
    .ovf_hit   (ovf_hit_w),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

endmodule

// File: rtl/evlog_writer_chk.sv
module evlog_writer_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_we,
  input logic [IDX_W-1:0] mem_addr,
  input logic [IDX_W-1:0] tail,
  input logic             ovf,
  input logic             ie,
  input logic             halt,
  input logic             irq
);

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq == (ovf && ie));

  a_r3_write_at_old_tail: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == $past(tail)));

  a_r12_tail_steps_by_one: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (tail == IDX_W'($past(tail) + 1'b1)));

  a_r5_tail_moves_with_write: assert property (@(posedge clk) disable iff (rst)
    (tail != $past(tail)) |-> mem_we);

  a_r5_overflow_drops: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> !mem_we);

  a_r8_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    $past(halt) |-> !mem_we);

endmodule

bind evlog_writer evlog_writer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .tail     (tail_w),
  .ovf      (ovf_w),
  .ie       (ie_w),
  .halt     (halt_w),
  .irq      (irq)
);

// File: tb/evlog_writer_bench.sv
module evlog_writer_bench;

  localparam int REC_W = 16;
  localparam int IDX_W = 2;
  localparam int REG_W = 3;
  localparam int N     = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ev_valid = 1'b0;
  logic             ev_ready;
  logic [REC_W-1:0] ev_data = '0;
  logic             reg_wr_en = 1'b0;
  logic [1:0]       reg_waddr = '0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [1:0]       reg_raddr = '0;
  logic [REG_W-1:0] reg_rdata;
  logic             mem_we;
  logic [IDX_W-1:0] mem_addr;
  logic [REC_W-1:0] mem_wdata;
  logic             irq;

  logic [REC_W-1:0] mem [N];
  int               wr_count = 0;
  int               nchecks  = 0;
  int               nfail    = 0;
  bit               done     = 1'b0;

  always #2 clk = ~clk;

  evlog_writer #(.REC_W(REC_W), .IDX_W(IDX_W)) u_evlog_writer (
    .clk, .rst, .ev_valid, .ev_ready, .ev_data,
    .reg_wr_en, .reg_waddr, .reg_wdata, .reg_raddr, .reg_rdata,
    .mem_we, .mem_addr, .mem_wdata, .irq
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_count      <= wr_count + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    nchecks++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(int addr, int data);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_waddr = 2'(addr);
    reg_wdata = REG_W'(data);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(int addr, output int val);
    @(negedge clk);
    reg_raddr = 2'(addr);
    @(negedge clk);
    val = int'(reg_rdata);
  endtask

  task automatic push(int data);
    @(negedge clk);
    ev_valid = 1'b1;
    ev_data  = REC_W'(data);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // control encoding: 1 = enable, 2 = irq enable, 4 = overflow
  task automatic t_reset;
    int v;
    reg_rd(0, v); chk("R1 ctrl", v, 0);
    reg_rd(1, v); chk("R1 head", v, 0);
    reg_rd(2, v); chk("R1 tail", v, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 writes", wr_count, 0);
    chk("R9 ready", int'(ev_ready), 1);
  endtask

  task automatic t_disabled;
    int v;
    push(16'h0011);
    idle(2);
    chk("R9 disabled no write", wr_count, 0);
    reg_rd(2, v); chk("R9 disabled tail", v, 0);
    reg_rd(0, v); chk("R9 disabled no overflow", v, 0);
  endtask

  task automatic t_fill;
    int v;
    reg_wr(0, 1);
    push(16'hA001);
    push(16'hA002);
    push(16'hA003);
    idle(2);
    chk("R3 write count", wr_count, 3);
    chk("R3 slot0", int'(mem[0]), 16'hA001);
    chk("R3 slot1", int'(mem[1]), 16'hA002);
    chk("R3 slot2", int'(mem[2]), 16'hA003);
    reg_rd(2, v); chk("R2 tail readback", v, 3);
    reg_rd(0, v); chk("R4 three slots fit", v, 1);
    chk("R9 ready while running", int'(ev_ready), 1);
  endtask

  task automatic t_overflow;
    int v;
    push(16'hA004);
    idle(2);
    chk("R5 full event dropped", wr_count, 3);
    reg_rd(2, v); chk("R5 tail held", v, 3);
    reg_rd(0, v); chk("R4 full sets overflow", v, 5);
    chk("R7 irq masked", int'(irq), 0);
    reg_wr(0, 3);
    chk("R7 irq raised", int'(irq), 1);
    reg_rd(0, v); chk("R6 write 0 keeps flag", v, 7);
  endtask

  task automatic t_halted;
    int v;
    reg_wr(1, 3);
    reg_rd(1, v); chk("R2 head readback", v, 3);
    push(16'hB001);
    idle(2);
    chk("R8 halted with space", wr_count, 3);
    reg_wr(0, 7);
    chk("R7 irq drops with flag", int'(irq), 0);
    reg_rd(0, v); chk("R6 w1c clears", v, 3);
    push(16'hB002);
    idle(2);
    chk("R10 rewrite 1 no resume", wr_count, 3);
    reg_rd(0, v); chk("R9 halted no overflow", v, 3);
  endtask

  task automatic t_restart_wrap;
    int v;
    reg_wr(0, 2);
    reg_wr(0, 3);
    push(16'hC001);
    push(16'hC002);
    push(16'hC003);
    idle(2);
    chk("R10 resumed", wr_count, 6);
    chk("R12 slot3", int'(mem[3]), 16'hC001);
    chk("R12 wrapped slot0", int'(mem[0]), 16'hC002);
    chk("R12 wrapped slot1", int'(mem[1]), 16'hC003);
    reg_rd(2, v); chk("R12 tail after wrap", v, 2);
    push(16'hC004);
    idle(2);
    chk("R4 full after wrap", wr_count, 6);
    reg_rd(0, v); chk("R5 overflow again", v, 7);
    chk("R7 irq again", int'(irq), 1);
  endtask

  task automatic t_combined;
    int v;
    reg_wr(0, 2);
    reg_rd(0, v); chk("R6 flag kept on disable", v, 6);
    reg_wr(0, 7);
    reg_rd(0, v); chk("R11 flag cleared", v, 3);
    reg_wr(1, 2);
    push(16'hD001);
    idle(2);
    chk("R11 combined write no resume", wr_count, 6);
    reg_wr(0, 2);
    reg_wr(0, 3);
    push(16'hD002);
    idle(2);
    chk("R10 toggle resumes", wr_count, 7);
    chk("R3 record at tail", int'(mem[2]), 16'hD002);
    reg_wr(2, 1);
    reg_rd(2, v); chk("R2 tail read-only", v, 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_fill();
    t_overflow();
    t_halted();
    t_restart_wrap();
    t_combined();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

endmodule